// File: doc/BRIEF.md
# LCD Controller Reset Sequencer

This block runs on the host side and brings an LCD controller out of reset safely after power-on. It drives three lines. The first is the controller's active-low reset line. The second enables the LCD panel's power supplies. The third is a ready flag that gates the host's command path. All durations are parameters given in nanoseconds together with the clock period, and each one is converted to a whole number of cycles at elaboration time.

A sequence starts when the system reset is released or when the host raises a synchronous restart request. The block then does three things in order:

- It holds the controller in reset for the minimum reset width. While reset is held, the controller's drive outputs are stopped and the panel counts as blanked.
- It keeps panel power off for at least one frame, counted from the moment reset asserted.
- After reset releases, it waits out a stabilization delay and then raises ready at once, so that initialization commands can follow without a gap.

The sequencer walks through a hold phase, a release-wait phase and a ready phase, in that order. A restart request drops all three outputs in the same cycle and begins the whole sequence again.

Top module: `lcd_rst_seq`

## Requirements
- R1: After a sequence start, `lcd_res_n` stays low and rises at exactly the HOLD-th rising clock edge. HOLD is the reset width converted to cycles.
- R2: `panel_pwr_en` rises at exactly edge max(HOLD, FRAME) after the start, where FRAME is the frame period in cycles. It is low before that edge.
- R3: `cmd_ready` is never high while `lcd_res_n` is low.
- R4: `cmd_ready` rises at exactly edge HOLD + STAB after the start, where STAB is the stabilization delay in cycles. It is low before that edge.
- R5: Once high, each output stays high until a restart request or a system reset.
- R6: While `rerun_req` is 1, all three outputs read 0 in that same cycle. Each clock edge that samples `rerun_req` = 1 becomes the start of a new sequence.
- R7: Each cycle count is the ceiling of its duration divided by the clock period, so no interval is shorter than specified. For example, 505 ns at a 10 ns clock gives 51 cycles.
- R8: When FRAME is not greater than HOLD, panel power rises on the same edge as the reset release.
- R9: While `rst_n` is low, all three outputs are 0. Releasing `rst_n` counts as a sequence start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset (power-on) |
| rerun_req | input | 1 | Synchronous request to restart the whole sequence |
| lcd_res_n | output | 1 | Active-low reset to the LCD controller |
| panel_pwr_en | output | 1 | Enable for the panel power supplies |
| cmd_ready | output | 1 | High when initialization commands may be issued |

## Verification
Each result is due a known number of edges after a sequence start:

- the reset release after HOLD edges;
- panel power after max(HOLD, FRAME) edges;
- ready after HOLD + STAB edges.

The effect of a restart request appears combinationally in the cycle it is raised. The bench drives inputs one nanosecond after a rising edge and samples outputs on the falling edge. It compares them against an edge counter that it keeps itself and that restarts on the same edges as the design. Two instances are checked together: one where the frame window outlasts the reset hold, and one where it does not.

// File: rtl/lcd_rst_pkg.sv
package lcd_rst_pkg;

   typedef enum logic [1:0] {
      ST_HOLD    = 2'd0,
      ST_SETTLE  = 2'd1,
      ST_READY   = 2'd2
   } seq_state_e;

   // Whole cycles covering a duration, never shorter than asked
   function automatic int unsigned ns_to_cycles(input int unsigned dur_ns,
                                                input int unsigned clk_ns);
      return (dur_ns + clk_ns - 1) / clk_ns;
   endfunction

endpackage

// File: rtl/lcd_rst_timer.sv
module lcd_rst_timer #(
   parameter int unsigned W       = 8,
   parameter int unsigned INIT_VAL = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         done
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= W'(INIT_VAL);
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);

endmodule

// File: rtl/lcd_rst_frame_win.sv
module lcd_rst_frame_win #(
   parameter int unsigned FRAME_CYC = 4,
   parameter int unsigned HOLD_CYC  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic win_done
);

   localparam int unsigned FW = $clog2(FRAME_CYC) + 1;

   generate
      if (FRAME_CYC > HOLD_CYC) begin : g_timer
         lcd_rst_timer #(
            .W        (FW),
            .INIT_VAL (FRAME_CYC - 1)
         ) u_frame_tmr (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (restart),
            .load_val (FW'(FRAME_CYC - 1)),
            .done     (win_done)
         );
      end else begin : g_covered
         // The hold phase already spans the whole frame window
         logic unused_sig;
         assign unused_sig = &{1'b0, clk, rst_n, restart};
         assign win_done   = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/lcd_rst_seq.sv
module lcd_rst_seq #(
   parameter int unsigned CLK_NS   = 20,
   parameter int unsigned HOLD_NS  = 1_000_000,
   parameter int unsigned FRAME_NS = 16_667_000,
   parameter int unsigned STAB_NS  = 3_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rerun_req,
   output logic lcd_res_n,
   output logic panel_pwr_en,
   output logic cmd_ready
);
   import lcd_rst_pkg::*;

   localparam int unsigned RST_CYC   = ns_to_cycles(HOLD_NS, CLK_NS);
   localparam int unsigned FRAME_CYC = ns_to_cycles(FRAME_NS, CLK_NS);
   localparam int unsigned STAB_CYC  = ns_to_cycles(STAB_NS, CLK_NS);
   localparam int unsigned MAX_CYC   = (RST_CYC > STAB_CYC) ? RST_CYC : STAB_CYC;
   localparam int unsigned TW        = $clog2(MAX_CYC) + 1;
   localparam logic [TW-1:0] HOLD_M1 = TW'(RST_CYC - 1);
   localparam logic [TW-1:0] STAB_M1 = TW'(STAB_CYC - 1);

   if (CLK_NS == 0) begin : g_bad_clk
      $error("lcd_rst_seq: CLK_NS must be non-zero");
   end
   if (HOLD_NS == 0 || FRAME_NS == 0 || STAB_NS == 0) begin : g_bad_dur
      $error("lcd_rst_seq: every duration must be non-zero");
   end

   seq_state_e    state_q, state_d;
   logic          res_q, res_d;
   logic          pwr_q, pwr_d;
   logic          rdy_q, rdy_d;
   logic          tmr_load;
   logic [TW-1:0] tmr_val;
   logic          tmr_done;
   logic          win_done;

   // One counter serves the hold phase, then the settle phase
   lcd_rst_timer #(
      .W        (TW),
      .INIT_VAL (RST_CYC - 1)
   ) u_phase_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .done     (tmr_done)
   );

   lcd_rst_frame_win #(
      .FRAME_CYC (FRAME_CYC),
      .HOLD_CYC  (RST_CYC)
   ) u_frame_win (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (rerun_req),
      .win_done (win_done)
   );

   always_comb begin
      state_d  = state_q;
      tmr_load = 1'b0;
      tmr_val  = HOLD_M1;
      res_d    = res_q;
      rdy_d    = rdy_q;
      if (rerun_req) begin
         state_d  = ST_HOLD;
         tmr_load = 1'b1;
         res_d    = 1'b0;
         rdy_d    = 1'b0;
      end else begin
         unique case (state_q)
            ST_HOLD: if (tmr_done) begin
               state_d  = ST_SETTLE;
               tmr_load = 1'b1;
               tmr_val  = STAB_M1;
               res_d    = 1'b1;
            end
            ST_SETTLE: if (tmr_done) begin
               state_d = ST_READY;
               rdy_d   = 1'b1;
            end
            default: ;
         endcase
      end
      pwr_d = !rerun_req && win_done && ((state_q != ST_HOLD) || tmr_done);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_HOLD;
         res_q   <= 1'b0;
         pwr_q   <= 1'b0;
         rdy_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         res_q   <= res_d;
         pwr_q   <= pwr_d;
         rdy_q   <= rdy_d;
      end
   end

   // A restart request takes effect in the cycle it is raised
   assign lcd_res_n    = res_q & ~rerun_req;
   assign panel_pwr_en = pwr_q & ~rerun_req;
   assign cmd_ready    = rdy_q & ~rerun_req;

endmodule

// File: rtl/lcd_rst_seq_chk.sv
module lcd_rst_seq_chk #(
   parameter int unsigned RST_CYC   = 1,
   parameter int unsigned FRAME_CYC = 1,
   parameter int unsigned STAB_CYC  = 1
) (
   input logic clk,
   input logic rst_n,
   input logic rerun_req,
   input logic lcd_res_n,
   input logic panel_pwr_en,
   input logic cmd_ready
);

   logic [31:0] res_low_run, res_high_run, pwr_low_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_low_run  <= '0;
         res_high_run <= '0;
         pwr_low_run  <= '0;
      end else begin
         res_low_run  <= lcd_res_n ? '0 :
                         (res_low_run == '1 ? res_low_run : res_low_run + 1);
         res_high_run <= !lcd_res_n ? '0 :
                         (res_high_run == '1 ? res_high_run : res_high_run + 1);
         pwr_low_run  <= panel_pwr_en ? '0 :
                         (pwr_low_run == '1 ? pwr_low_run : pwr_low_run + 1);
      end
   end

   a_r1_hold_width: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lcd_res_n) |-> (res_low_run >= RST_CYC));

   a_r2_frame_blank: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(panel_pwr_en) |-> (pwr_low_run >= FRAME_CYC));

   a_r2_pwr_after_release: assert property (@(posedge clk) disable iff (!rst_n)
      panel_pwr_en |-> lcd_res_n);

   a_r3_no_cmd_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
      !lcd_res_n |-> !cmd_ready);

   a_r4_settle_wait: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmd_ready) |-> (res_high_run >= STAB_CYC));

   a_r5_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_ready && !rerun_req) |=> (cmd_ready || rerun_req));

   a_r6_restart_resets: assert property (@(posedge clk) disable iff (!rst_n)
      rerun_req |=> !lcd_res_n && !cmd_ready);

endmodule

bind lcd_rst_seq lcd_rst_seq_chk #(
   .RST_CYC   (RST_CYC),
   .FRAME_CYC (FRAME_CYC),
   .STAB_CYC  (STAB_CYC)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .rerun_req    (rerun_req),
   .lcd_res_n    (lcd_res_n),
   .panel_pwr_en (panel_pwr_en),
   .cmd_ready    (cmd_ready)
);

// File: tb/test_lcd_rst_seq.sv
module test_lcd_rst_seq;

   localparam int CLK_PERIOD = 10;
   // Expected cycle counts, worked out by hand from R7
   localparam int EXP_HOLD  = 51;   // 505 ns
   localparam int EXP_FRAME = 78;   // 777 ns
   localparam int EXP_STAB  = 31;   // 303 ns
   localparam int EXP_FRAME_S = 20; // 195 ns, shorter than the hold
   localparam int WATCHDOG  = 100_000;

   logic clk = 1'b0;
   logic rst_n, rerun;
   logic res_a, pwr_a, rdy_a, res_b, pwr_b, rdy_b;
   int   t_model;
   int   n_checks = 0, n_fail = 0, cyc = 0;
   bit   done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lcd_rst_seq #(.CLK_NS(10), .HOLD_NS(505), .FRAME_NS(777), .STAB_NS(303))
   i_lcd_rst_seq (.clk(clk), .rst_n(rst_n), .rerun_req(rerun),
                  .lcd_res_n(res_a), .panel_pwr_en(pwr_a), .cmd_ready(rdy_a));

   lcd_rst_seq #(.CLK_NS(10), .HOLD_NS(505), .FRAME_NS(195), .STAB_NS(303))
   i_lcd_rst_seq_short (.clk(clk), .rst_n(rst_n), .rerun_req(rerun),
                        .lcd_res_n(res_b), .panel_pwr_en(pwr_b), .cmd_ready(rdy_b));

   // Edges since the last sequence start
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n)            t_model <= 0;
      else if (rerun)        t_model <= 0;
      else if (t_model < 1_000_000) t_model <= t_model + 1;
   end

   function automatic logic exp_out(input int t, input int thr, input logic rr,
                                    input logic rn);
      return rn && !rr && (t >= thr);
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   task automatic check(input string tag, input string what, input logic act,
                        input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s at t=%0d: actual %b expected %b", tag, what,
                  t_model, act, exp);
      end
   endtask

   function automatic string tag_for(input string base);
      if (!rst_n) return "R9";
      if (rerun)  return "R6";
      return base;
   endfunction

   always @(negedge clk) begin
      if (!done) begin
         // R1 / R7: reset release boundary is at 51 cycles
         check((t_model == EXP_HOLD) ? "R7" : tag_for("R1"), "res_n",
               res_a, exp_out(t_model, EXP_HOLD, rerun, rst_n));
         check(tag_for("R2"), "pwr",
               pwr_a, exp_out(t_model, max2(EXP_HOLD, EXP_FRAME), rerun, rst_n));
         check(tag_for((t_model > EXP_HOLD + EXP_STAB) ? "R5" : "R4"), "ready",
               rdy_a, exp_out(t_model, EXP_HOLD + EXP_STAB, rerun, rst_n));
         check(tag_for("R1"), "res_n short", res_b,
               exp_out(t_model, EXP_HOLD, rerun, rst_n));
         check(tag_for("R8"), "pwr short", pwr_b,
               exp_out(t_model, max2(EXP_HOLD, EXP_FRAME_S), rerun, rst_n));
         check(tag_for("R4"), "ready short", rdy_b,
               exp_out(t_model, EXP_HOLD + EXP_STAB, rerun, rst_n));
         check("R3", "ready while in reset", rdy_a && !res_a, 1'b0);
      end
   end

   task automatic step(input int n);
      repeat (n) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic pulse(input int n);
      rerun = 1'b1;
      step(n);
      rerun = 1'b0;
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures",
                  n_checks, n_fail);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > WATCHDOG && !done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WATCHDOG);
         finish_run();
      end
   end

   initial begin
      void'($urandom(32'h0001_5EED));
      rst_n = 1'b0;
      rerun = 1'b0;
      step(3);
      rst_n = 1'b1;                // R9: release starts the sequence
      step(200);
      pulse(1);  step(20);         // R6: restart during hold
      pulse(1);  step(60);         // restart during settle
      pulse(3);  step(EXP_HOLD - 1);
      pulse(1);  step(150);        // restart one edge before release
      rst_n = 1'b0; step(2);       // R9: system reset mid-run
      rst_n = 1'b1; step(EXP_HOLD + EXP_STAB + 5);
      for (int i = 0; i < 40; i++) begin
         step($urandom % 160);
         pulse(1 + ($urandom % 3));
      end
      step(200);
      finish_run();
   end

endmodule